// File: doc/BRIEF.md
# Beep Tone Generator with Speed-Compensated Tap

The block produces a square-wave beep from a counter that never stops. The counter advances once every two system clocks. Software writes a bit-select word with a single bit set in its select field. That bit picks which counter bit drives the tone output. A separate enable byte decides whether the tone reaches the output pin.

The frequency sequencer reports the current system clock speed. When the system runs slower, the block moves the chosen counter tap down by the matching number of bits, so the audible pitch does not change. The output is registered and is a plain logic-level square wave.

Top module: `beep_tone_gen`

## Requirements
- R1: After reset the counter is zero. It advances by one on every second rising clock edge, starting with the second edge after reset, and wraps at its width. It runs whether or not the tone is enabled.
- R2: `beep_o` is registered. After each rising edge it shows the selected counter bit as it stood just before that edge. With field bit 0 (tap 10) at full speed, the output period is 2^12 system clocks.
- R3: A write with `wr_addr`=1 stores `wr_data[18:10]` as the select field. Field bit i picks counter bit 10+i. The other bits of the word are ignored.
- R4: `speed` encoding: 0 = full speed, tap unchanged. 1 = half speed, tap lowered by 1. 2 = 1/32 speed, tap lowered by 5. 3 = treated as full speed. A lowered tap never goes below counter bit 0.
- R5: If the select field is zero, or has more than one bit set, `beep_o` stays low.
- R6: A write with `wr_addr`=0 stores `wr_data[0]` as the enable. Bits 7:1 are ignored. While the enable is 0, `beep_o` stays low. When the enable returns to 1, the tone resumes in the phase of the counter that kept running.
- R7: During reset and right after it, `beep_o` is low, the enable is 0 and the select field is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = enable byte, 1 = bit-select word |
| wr_data | input | 32 | Write data |
| speed | input | 2 | Current system clock speed code |
| beep_o | output | 1 | Tone output |

## Verification
The hardest condition to reach is a lowered tap hitting counter bit 0. This cannot happen with the default field position, because the lowest tap there is 10 and the largest shift is 5. The bench therefore adds a second instance whose field starts at bit 3. It sweeps every field value against every speed code on that instance, which drives the saturation case and the invalid-field case directly. The long tap-10 run and the disable/re-enable run on the default instance check pitch and counter continuity against a cycle count kept in the bench.

// File: rtl/beep_pkg.sv
package beep_pkg;

  typedef enum logic [1:0] {
    SPD_FULL = 2'd0,
    SPD_HALF = 2'd1,
    SPD_SLOW = 2'd2,
    SPD_RSVD = 2'd3
  } speed_e;

  localparam int HALF_SHIFT = 1;
  localparam int SLOW_SHIFT = 5;

  // number of counter bits the tap drops for a given clock speed
  function automatic int shift_for(speed_e spd);
    case (spd)
      SPD_HALF: return HALF_SHIFT;
      SPD_SLOW: return SLOW_SHIFT;
      default:  return 0;
    endcase
  endfunction

  // lowered tap, clamped at counter bit 0
  function automatic int tap_for(int base, int shift);
    if (base <= shift) return 0;
    return base - shift;
  endfunction

endpackage

// File: rtl/beep_half_counter.sv
module beep_half_counter #(
  parameter int CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic             step
);
  logic             half_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      half_q <= ~half_q;
      if (half_q) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt  = cnt_q;
  assign step = half_q;

  AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cnt == $past(cnt) + CNT_W'(1)); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt)); // R1
endmodule

// File: rtl/beep_regs.sv
module beep_regs #(
  parameter int SEL_LSB = 10,
  parameter int SEL_W   = 9,
  parameter int REG_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [REG_W-1:0] wr_data,
  output logic             en,
  output logic [SEL_W-1:0] sel_field
);
  localparam int SEL_MSB = SEL_LSB + SEL_W - 1;

  logic             en_q;
  logic [SEL_W-1:0] sel_q;
  logic             hit_en, hit_sel;

  assign hit_en  = wr_en && (wr_addr == 1'b0);
  assign hit_sel = wr_en && (wr_addr == 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else begin
      if (hit_en)  en_q  <= wr_data[0];
      if (hit_sel) sel_q <= wr_data[SEL_MSB:SEL_LSB];
    end
  end

  // reserved bits are accepted and dropped
  logic unused_rsv;
  assign unused_rsv = ^{wr_data[REG_W-1:SEL_MSB+1], wr_data[SEL_LSB-1:1]};

  assign en        = en_q;
  assign sel_field = sel_q;

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_sel |=> $stable(sel_field)); // R3
  AST_EN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_en |=> $stable(en)); // R6
endmodule

// File: rtl/beep_tap_map.sv
module beep_tap_map #(
  parameter int SEL_LSB = 10,
  parameter int SEL_W   = 9,
  parameter int TAP_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_field,
  input  logic [1:0]       speed,
  output logic [TAP_W-1:0] tap,
  output logic             sel_ok
);
  import beep_pkg::*;

  int idx;

  always_comb begin
    idx = 0;
    for (int i = 0; i < SEL_W; i++) begin
      if (sel_field[i]) idx = i;
    end
    tap = TAP_W'(tap_for(SEL_LSB + idx, shift_for(speed_e'(speed))));
  end

  assign sel_ok = $onehot(sel_field);

  AST_FULL_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ok && speed == 2'd0) |-> int'(tap) >= SEL_LSB); // R4
  AST_SLOW_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ok && speed == 2'd2) |-> int'(tap) <= SEL_LSB + SEL_W - 1 - SLOW_SHIFT
                                  || tap == '0); // R4
endmodule

// File: rtl/beep_tone_gen.sv
module beep_tone_gen #(
  parameter int SEL_LSB = 10,
  parameter int SEL_W   = 9,
  parameter int CNT_W   = SEL_LSB + SEL_W
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  speed,
  output logic        beep_o
);
  localparam int TAP_W = $clog2(CNT_W);

  logic [CNT_W-1:0] cnt;
  logic             step;
  logic             en;
  logic [SEL_W-1:0] sel_field;
  logic [TAP_W-1:0] tap;
  logic             sel_ok;
  logic             beep_q;

  beep_half_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .step(step));

  beep_regs #(.SEL_LSB(SEL_LSB), .SEL_W(SEL_W), .REG_W(32)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .en(en), .sel_field(sel_field));

  beep_tap_map #(.SEL_LSB(SEL_LSB), .SEL_W(SEL_W), .TAP_W(TAP_W)) u_map (
    .clk(clk), .rst_n(rst_n), .sel_field(sel_field), .speed(speed),
    .tap(tap), .sel_ok(sel_ok));

  always_ff @(posedge clk) begin
    if (!rst_n) beep_q <= 1'b0;
    else        beep_q <= en & sel_ok & cnt[tap];
  end

  assign beep_o = beep_q;

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !beep_o); // R6
  AST_BADSEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ok |=> !beep_o); // R5
  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |=> !beep_o); // R7
endmodule

// File: tb/beep_tone_gen_test.sv
module beep_tone_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  logic        a_wr_en = 1'b0, a_wr_addr = 1'b0;
  logic [31:0] a_wr_data = '0;
  logic [1:0]  a_speed = 2'd0;
  logic        a_beep;
  logic        b_wr_en = 1'b0, b_wr_addr = 1'b0;
  logic [31:0] b_wr_data = '0;
  logic [1:0]  b_speed = 2'd0;
  logic        b_beep;

  beep_tone_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(a_wr_en), .wr_addr(a_wr_addr),
    .wr_data(a_wr_data), .speed(a_speed), .beep_o(a_beep));

  beep_tone_gen #(.SEL_LSB(3), .SEL_W(4), .CNT_W(7)) uut_small (
    .clk(clk), .rst_n(rst_n), .wr_en(b_wr_en), .wr_addr(b_wr_addr),
    .wr_data(b_wr_data), .speed(b_speed), .beep_o(b_beep));

  int vectors = 0;
  int misses  = 0;
  int unsigned edges = 0;
  bit done = 1'b0;
  string req_a = "R7";
  string req_b = "R7";
  logic m_en_a = 1'b0, m_en_b = 1'b0;
  logic [31:0] m_word_a = '0, m_word_b = '0;

  function automatic logic expect_bit(logic en, logic [31:0] word, logic [1:0] spd,
                                      int unsigned e, int lsb, int w, int cw);
    int hits, pos, drop, t;
    int unsigned c;
    hits = 0; pos = 0;
    for (int i = 0; i < w; i++) if (word[lsb+i]) begin hits++; pos = i; end
    if (!en || hits != 1) return 1'b0;
    drop = (spd == 2'd1) ? 1 : (spd == 2'd2) ? 5 : 0;
    t = lsb + pos - drop;
    if (t < 0) t = 0;
    c = (e / 2) % (32'd1 << cw);
    return logic'((c >> t) & 1);
  endfunction

  task automatic check(string req, string which, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s beep_%s actual=%0b expected=%0b edge=%0d", req, which, act, exp, edges);
    end
  endtask

  task automatic cyc();
    logic ea, eb;
    ea = expect_bit(m_en_a, m_word_a, a_speed, edges, 10, 9, 19);
    eb = expect_bit(m_en_b, m_word_b, b_speed, edges, 3, 4, 7);
    if (a_wr_en) begin if (a_wr_addr) m_word_a = a_wr_data; else m_en_a = a_wr_data[0]; end
    if (b_wr_en) begin if (b_wr_addr) m_word_b = b_wr_data; else m_en_b = b_wr_data[0]; end
    edges++;
    @(posedge clk);
    @(negedge clk);
    a_wr_en = 1'b0;
    b_wr_en = 1'b0;
    check(req_a, "a", a_beep, ea);
    check(req_b, "b", b_beep, eb);
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  task automatic wr_a(logic addr, logic [31:0] d);
    a_wr_en = 1'b1; a_wr_addr = addr; a_wr_data = d; cyc();
  endtask

  task automatic wr_b(logic addr, logic [31:0] d);
    b_wr_en = 1'b1; b_wr_addr = addr; b_wr_data = d; cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7", "a", a_beep, 1'b0); // R7 reset state
    check("R7", "b", b_beep, 1'b0);
    rst_n = 1'b1;
    run(8); // R7: still low, nothing configured

    // R2: default tap bit 10, full speed, full period 2^12
    req_a = "R2";
    wr_a(1'b0, 32'h1);
    wr_a(1'b1, 32'h1 << 10);
    run(8200);

    // R4: every field bit against every speed code
    req_a = "R4";
    for (int s = 0; s < 4; s++) begin
      a_speed = 2'(s);
      for (int i = 0; i < 9; i++) begin
        wr_a(1'b1, 32'h1 << (10 + i));
        run(64);
      end
    end
    a_speed = 2'd0;

    // R5: zero and multi-bit fields
    req_a = "R5";
    wr_a(1'b1, 32'h0);
    run(100);
    wr_a(1'b1, (32'h1 << 10) | (32'h1 << 11));
    run(100);
    wr_a(1'b1, 32'h0007fc00);
    run(100);

    // R3: reserved bits set around a valid field bit 12
    req_a = "R3";
    wr_a(1'b1, 32'hfff803ff | (32'h1 << 12));
    run(300);

    // R6: reserved enable bits, disable keeps counter running
    req_a = "R6";
    wr_a(1'b1, 32'h1 << 10);
    wr_a(1'b0, 32'hfe);
    run(3000);
    wr_a(1'b0, 32'hff);
    run(2100);

    // small instance: R1 tap 0 via 1/32 speed from field bit 0
    req_b = "R1";
    wr_b(1'b0, 32'h1);
    b_speed = 2'd2;
    wr_b(1'b1, 32'h1 << 3);
    run(300);

    // R4: saturation sweep over all 16 field values and speed codes
    req_b = "R4";
    for (int s = 0; s < 4; s++) begin
      b_speed = 2'(s);
      for (int f = 0; f < 16; f++) begin
        wr_b(1'b1, 32'(f) << 3);
        run(48);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule